// File: doc/BRIEF.md
# Programmable Almost-Full / Almost-Empty Flag Generator

This block produces two active-low threshold flags for a FIFO whose write and read sides run on separate clocks. It keeps its own write and read pointers, advanced by one-cycle increment strobes from the FIFO's qualified write and read enables. Each side compares its view of the fill level with two offsets. The almost-full flag fires when the free space has shrunk to the full offset. The almost-empty flag fires when the content has fallen to the empty offset plus one. Pointers cross between the domains in Gray code through a two-stage synchronizer.

A timing-mode input is sampled while master reset is held. A HIGH selects single-clock flags: the almost-full flag is a register on the write clock and the almost-empty flag is a register on the read clock. A LOW selects split-clock flags. In that mode each flag is raised to active by one clock and returned inactive by the other. The two sides exchange toggle bits, and each side acts only on what it has already seen of the other.

Top module: `levelFlagGen`

## Requirements
- R1: During and right after master reset (rstN LOW, synchronous to both clocks), almostFullN is 1 and almostEmptyN is 0.
- R2: almostFullN is driven to 0 once the write-side level reaches DEPTH minus fullOfs. The write-side level is the write count, including a write in the current cycle, minus the synchronized read count.
- R3: almostEmptyN is driven to 0 once the read-side level is at or below emptyOfs plus one. The read-side level is the synchronized write count minus the read count, including a read in the current cycle.
- R4: timingModeSel is captured on every clock edge while rstN is LOW (1 = single-clock, 0 = split-clock). A change on it after reset has no effect until the next reset.
- R5: In single-clock mode almostFullN is a write-clock register. A read is visible to it on the third write-clock edge after the read is taken, through a two-stage synchronizer.
- R6: In single-clock mode almostEmptyN is a read-clock register. A write is visible to it on the third read-clock edge after the write is taken.
- R7: In split-clock mode almostFullN is made active only by the write clock and made inactive only by the read clock. It is made inactive when the read-side level is below DEPTH minus fullOfs.
- R8: In split-clock mode almostEmptyN is made active only by the read clock and made inactive only by the write clock. It is made inactive when the write-side level exceeds emptyOfs plus one.
- R9: Reads from a full FIFO return almostFullN to 1 once the level drops below the almost-full threshold.
- R10: A new offset value is used for comparison from the second clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Master reset, active LOW, synchronous to each clock |
| timingModeSel | input | 1 | Flag timing mode, sampled during reset (1 single-clock, 0 split-clock) |
| wrInc | input | 1 | One word written this write-clock cycle |
| rdInc | input | 1 | One word read this read-clock cycle |
| emptyOfs | input | ADDR_W | Empty offset n |
| fullOfs | input | ADDR_W | Full offset m |
| almostFullN | output | 1 | Almost-full flag, active LOW |
| almostEmptyN | output | 1 | Almost-empty flag, active LOW |

## Verification
The bench targets the exact threshold words: level DEPTH-m against DEPTH-m-1, and n+1 against n+2. A compare off by one in either direction moves a flag one word early or late. It counts the three-edge synchronizer latency on every cycle, so a missing or extra stage shows up as a one-cycle skew. Split-clock mode runs under mixed traffic; a design that let the wrong side set or clear a flag, or that acted on an unseen toggle, would leave a flag stuck or chattering. The mode pin is flipped after reset and an offset is changed mid-run. This catches a mode latch that stays transparent and a threshold register that is skipped or doubled.

// File: rtl/flagPkg.sv
package flagPkg;
  // Threshold compares produced by the datapath for the flag control
  typedef struct packed {
    logic fullishW;   // write-side level at/above almost-full threshold
    logic lowishW;    // write-side level at/below almost-empty threshold
    logic fullishR;   // read-side level at/above almost-full threshold
    logic lowishR;    // read-side level at/below almost-empty threshold
  } cmpStrobes_t;
endpackage

// File: rtl/flagLevelPath.sv
module flagLevelPath
  import flagPkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrInc,
  input  logic              rdInc,
  input  logic [ADDR_W-1:0] emptyOfs,
  input  logic [ADDR_W-1:0] fullOfs,
  output cmpStrobes_t       cmp
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] wrBin, wrGray, rdBin, rdGray;
  logic [PTR_W-1:0] rdGraySeen [SYNC_STAGES];
  logic [PTR_W-1:0] wrGraySeen [SYNC_STAGES];
  logic [PTR_W-1:0] fullThrW, lowThrW, fullThrR, lowThrR;
  logic [PTR_W-1:0] wrBinNext, rdBinNext, levelW, levelR;

  assign wrBinNext = wrBin + PTR_W'(wrInc);
  assign rdBinNext = rdBin + PTR_W'(rdInc);

  // write domain: own pointer plus synchronized read pointer
  always_ff @(posedge wrClk) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
      for (int s = 0; s < SYNC_STAGES; s++) rdGraySeen[s] <= '0;
    end else begin
      wrBin  <= wrBinNext;
      wrGray <= toGray(wrBinNext);
      rdGraySeen[0] <= rdGray;
      for (int s = 1; s < SYNC_STAGES; s++) rdGraySeen[s] <= rdGraySeen[s-1];
    end
  end

  // read domain: own pointer plus synchronized write pointer
  always_ff @(posedge rdClk) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
      for (int s = 0; s < SYNC_STAGES; s++) wrGraySeen[s] <= '0;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= toGray(rdBinNext);
      wrGraySeen[0] <= wrGray;
      for (int s = 1; s < SYNC_STAGES; s++) wrGraySeen[s] <= wrGraySeen[s-1];
    end
  end

  // thresholds registered per domain, loaded every edge (also in reset)
  always_ff @(posedge wrClk) begin
    fullThrW <= DEPTH_P - PTR_W'(fullOfs);
    lowThrW  <= PTR_W'(emptyOfs) + PTR_W'(1);
  end

  always_ff @(posedge rdClk) begin
    fullThrR <= DEPTH_P - PTR_W'(fullOfs);
    lowThrR  <= PTR_W'(emptyOfs) + PTR_W'(1);
  end

  assign levelW = wrBinNext - fromGray(rdGraySeen[SYNC_STAGES-1]);
  assign levelR = fromGray(wrGraySeen[SYNC_STAGES-1]) - rdBinNext;

  always_comb begin
    cmp.fullishW = (levelW >= fullThrW);
    cmp.lowishW  = (levelW <= lowThrW);
    cmp.fullishR = (levelR >= fullThrR);
    cmp.lowishR  = (levelR <= lowThrR);
  end

  AST_WR_GRAY_ONE_BIT: assert property (@(posedge wrClk) disable iff (!rstN)
    $countones(wrGray ^ $past(wrGray)) <= 1); // R5
  AST_RD_GRAY_ONE_BIT: assert property (@(posedge rdClk) disable iff (!rstN)
    $countones(rdGray ^ $past(rdGray)) <= 1); // R6
endmodule

// File: rtl/flagCrossCell.sv
module flagCrossCell #(
  parameter bit INIT_ACTIVE = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic setClk,
  input  logic clrClk,
  input  logic rstN,
  input  logic setCond,
  input  logic clrCond,
  output logic active
);
  logic setTog, clrTog;
  logic [SYNC_STAGES-1:0] clrSeen, setSeen;
  logic setBelief, clrBelief;

  // each side judges the flag from its own toggle and the other's synced toggle
  assign setBelief = INIT_ACTIVE ^ setTog ^ clrSeen[SYNC_STAGES-1];
  assign clrBelief = INIT_ACTIVE ^ clrTog ^ setSeen[SYNC_STAGES-1];

  always_ff @(posedge setClk) begin
    if (!rstN) begin
      setTog  <= 1'b0;
      clrSeen <= '0;
    end else begin
      if (!setBelief && setCond) setTog <= ~setTog;
      clrSeen <= {clrSeen[SYNC_STAGES-2:0], clrTog};
    end
  end

  always_ff @(posedge clrClk) begin
    if (!rstN) begin
      clrTog  <= 1'b0;
      setSeen <= '0;
    end else begin
      if (clrBelief && clrCond) clrTog <= ~clrTog;
      setSeen <= {setSeen[SYNC_STAGES-2:0], setTog};
    end
  end

  assign active = INIT_ACTIVE ^ setTog ^ clrTog;
endmodule

// File: rtl/flagControl.sv
module flagControl
  import flagPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        wrClk,
  input  logic        rdClk,
  input  logic        rstN,
  input  logic        timingModeSel,
  input  cmpStrobes_t cmp,
  output logic        almostFullN,
  output logic        almostEmptyN
);
  logic modeW, modeR;
  logic pafSyncN, paeSyncN;
  logic pafSplit, paeSplit;

  // mode captured while reset is held, per domain
  always_ff @(posedge wrClk) if (!rstN) modeW <= timingModeSel;
  always_ff @(posedge rdClk) if (!rstN) modeR <= timingModeSel;

  always_ff @(posedge wrClk) begin
    if (!rstN) pafSyncN <= 1'b1;
    else       pafSyncN <= !cmp.fullishW;
  end

  always_ff @(posedge rdClk) begin
    if (!rstN) paeSyncN <= 1'b0;
    else       paeSyncN <= !cmp.lowishR;
  end

  flagCrossCell #(.INIT_ACTIVE(1'b0), .SYNC_STAGES(SYNC_STAGES)) uPafCell (
    .setClk(wrClk), .clrClk(rdClk), .rstN(rstN),
    .setCond(cmp.fullishW), .clrCond(!cmp.fullishR), .active(pafSplit));

  flagCrossCell #(.INIT_ACTIVE(1'b1), .SYNC_STAGES(SYNC_STAGES)) uPaeCell (
    .setClk(rdClk), .clrClk(wrClk), .rstN(rstN),
    .setCond(cmp.lowishR), .clrCond(!cmp.lowishW), .active(paeSplit));

  assign almostFullN  = modeW ? pafSyncN : !pafSplit;
  assign almostEmptyN = modeR ? paeSyncN : !paeSplit;

  AST_MODE_HOLD_W: assert property (@(posedge wrClk) disable iff (!rstN)
    $stable(modeW)); // R4
  AST_PAF_SET_CAUSE: assert property (@(posedge wrClk) disable iff (!rstN)
    $fell(almostFullN) |-> $past(cmp.fullishW)); // R2
  AST_PAE_SET_CAUSE: assert property (@(posedge rdClk) disable iff (!rstN)
    $fell(almostEmptyN) |-> $past(cmp.lowishR)); // R3
  AST_PAF_SPLIT_CLEAR: assert property (@(posedge rdClk) disable iff (!rstN)
    (!modeR && $rose(almostFullN)) |-> !$past(cmp.fullishR)); // R7
  AST_PAE_SPLIT_CLEAR: assert property (@(posedge wrClk) disable iff (!rstN)
    (!modeW && $rose(almostEmptyN)) |-> !$past(cmp.lowishW)); // R8
endmodule

// File: rtl/levelFlagGen.sv
module levelFlagGen
  import flagPkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              timingModeSel,
  input  logic              wrInc,
  input  logic              rdInc,
  input  logic [ADDR_W-1:0] emptyOfs,
  input  logic [ADDR_W-1:0] fullOfs,
  output logic              almostFullN,
  output logic              almostEmptyN
);
  cmpStrobes_t cmpBus;

  flagLevelPath #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) uPath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrInc(wrInc), .rdInc(rdInc),
    .emptyOfs(emptyOfs), .fullOfs(fullOfs), .cmp(cmpBus));

  flagControl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .timingModeSel(timingModeSel), .cmp(cmpBus),
    .almostFullN(almostFullN), .almostEmptyN(almostEmptyN));
endmodule

// File: tb/tb_levelFlagGen.sv
module tb_levelFlagGen;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0, timingModeSel = 1'b1, wrInc = 1'b0, rdInc = 1'b0;
  logic [ADDR_W-1:0] emptyOfs = 4'd2, fullOfs = 4'd3;
  logic almostFullN, almostEmptyN;

  always #2.5 clk = ~clk;  // 200 MHz, both domains share it

  levelFlagGen #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) dut (
    .wrClk(clk), .rdClk(clk), .rstN(rstN), .timingModeSel(timingModeSel),
    .wrInc(wrInc), .rdInc(rdInc), .emptyOfs(emptyOfs), .fullOfs(fullOfs),
    .almostFullN(almostFullN), .almostEmptyN(almostEmptyN));

  int checks = 0, errors = 0, cycles = 0;
  string pafTag = "R5", paeTag = "R6";

  // behavioural reference: counts and their recent history
  int wCnt, rCnt, wH[1:3], rH[1:3];
  int pS, pC, pSH[1:3], pCH[1:3];   // almost-full set/clear event counts
  int eS, eC, eSH[1:3], eCH[1:3];   // almost-empty set/clear event counts
  int mReg, nReg;
  bit modeM, pafSyncE, paeSyncE, expPafN, expPaeN;

  task automatic check(string tag, logic got, logic exp, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      wCnt = 0; rCnt = 0; pS = 0; pC = 0; eS = 0; eC = 0;
      for (int i = 1; i <= 3; i++) begin
        wH[i] = 0; rH[i] = 0; pSH[i] = 0; pCH[i] = 0; eSH[i] = 0; eCH[i] = 0;
      end
      modeM = timingModeSel; pafSyncE = 1; paeSyncE = 0;
    end else begin
      int wn, rn, lvlW, lvlR, nS, nC;
      bit fW, fR, lW, lR;
      wn = wCnt + int'(wrInc); rn = rCnt + int'(rdInc);
      lvlW = wn - rH[3]; lvlR = wH[3] - rn;
      fW = lvlW >= DEPTH - mReg; fR = lvlR >= DEPTH - mReg;
      lW = lvlW <= nReg + 1;     lR = lvlR <= nReg + 1;
      pafSyncE = !fW; paeSyncE = !lR;
      nS = pS + int'(((pS - pCH[3]) != 1) && fW);
      nC = pC + int'(((pSH[3] - pC) == 1) && !fR);
      pSH[3] = pSH[2]; pSH[2] = pSH[1]; pSH[1] = nS; pS = nS;
      pCH[3] = pCH[2]; pCH[2] = pCH[1]; pCH[1] = nC; pC = nC;
      nS = eS + int'(((1 + eS - eCH[3]) != 1) && lR);
      nC = eC + int'(((1 + eSH[3] - eC) == 1) && !lW);
      eSH[3] = eSH[2]; eSH[2] = eSH[1]; eSH[1] = nS; eS = nS;
      eCH[3] = eCH[2]; eCH[2] = eCH[1]; eCH[1] = nC; eC = nC;
      wH[3] = wH[2]; wH[2] = wH[1]; wH[1] = wn; wCnt = wn;
      rH[3] = rH[2]; rH[2] = rH[1]; rH[1] = rn; rCnt = rn;
    end
    mReg = int'(fullOfs); nReg = int'(emptyOfs);
    expPafN = modeM ? pafSyncE : !((pS - pC) == 1);
    expPaeN = modeM ? paeSyncE : !((1 + eS - eC) == 1);
    #1;
    if (rstN) begin
      check(pafTag, almostFullN, expPafN, "almostFullN vs model");
      check(paeTag, almostEmptyN, expPaeN, "almostEmptyN vs model");
    end
  end

  // one cycle of stimulus, gated so the pointers stay within a legal FIFO
  task automatic stepCyc(bit w, bit r);
    wrInc = w && (wCnt + 1 - rH[1 + 2] <= DEPTH);
    rdInc = r && (rCnt + 1 <= wH[3]);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) stepCyc(0, 0);
  endtask

  task automatic doReset(bit mode);
    rstN = 0; timingModeSel = mode; fullOfs = 4'd3; emptyOfs = 4'd2;
    wrInc = 0; rdInc = 0;
    repeat (4) @(negedge clk);
    check("R1", almostFullN, 1'b1, "almostFullN in reset");
    check("R1", almostEmptyN, 1'b0, "almostEmptyN in reset");
    rstN = 1;
    @(negedge clk);
    check("R1", almostFullN, 1'b1, "almostFullN after reset");
    check("R1", almostEmptyN, 1'b0, "almostEmptyN after reset");
  endtask

  task automatic randomRun(int n, int pw, int pr);
    for (int i = 0; i < n; i++)
      stepCyc($urandom_range(0, 99) < pw, $urandom_range(0, 99) < pr);
  endtask

  task automatic levelWalk(string setTag, string clrTag);
    while (wCnt - rCnt < DEPTH) stepCyc(1, 0);
    idle(6);
    check(setTag, almostFullN, 1'b0, "full FIFO");
    while (wCnt - rCnt > DEPTH - 3) stepCyc(0, 1);   // level 13 = threshold
    idle(6);
    check("R2", almostFullN, 1'b0, "level at DEPTH-m");
    stepCyc(0, 1); idle(6);                          // level 12
    check("R9", almostFullN, 1'b1, "one below DEPTH-m after reads");
    check(clrTag, almostFullN, 1'b1, "almost-full released");
    while (wCnt - rCnt > 4) stepCyc(0, 1);
    idle(6);
    check("R3", almostEmptyN, 1'b1, "level n+2");
    stepCyc(0, 1); idle(6);                          // level 3 = n+1
    check("R3", almostEmptyN, 1'b0, "level n+1");
    while (wCnt - rCnt < 8) stepCyc(1, 0);
    idle(6);
    check(clrTag == "R7" ? "R8" : "R6", almostEmptyN, 1'b1, "almost-empty released");
  endtask

  initial begin
    @(negedge clk);
    // single-clock mode
    doReset(1'b1);
    levelWalk("R5", "R5");
    // offset change: level 8, threshold moves from 13 to 8
    check("R10", almostFullN, 1'b1, "before offset change");
    fullOfs = 4'd8;
    stepCyc(0, 0);
    stepCyc(0, 0);
    check("R10", almostFullN, 1'b0, "new full offset on second edge");
    pafTag = "R10"; idle(4); pafTag = "R5";
    randomRun(200, 70, 40);
    randomRun(200, 40, 70);
    // mode pin moves after reset: must be ignored
    timingModeSel = 1'b0; pafTag = "R4"; paeTag = "R4";
    randomRun(300, 55, 55);
    while (wCnt - rCnt < DEPTH) stepCyc(1, 0);
    idle(6);
    check("R4", almostFullN, 1'b0, "mode pin ignored after reset");

    // split-clock mode
    pafTag = "R7"; paeTag = "R8";
    doReset(1'b0);
    levelWalk("R7", "R7");
    randomRun(300, 70, 40);
    randomRun(300, 40, 70);
    randomRun(300, 55, 55);
    fullOfs = 4'd0; emptyOfs = 4'd15;
    randomRun(200, 50, 50);
    timingModeSel = 1'b1; pafTag = "R4"; paeTag = "R4";
    randomRun(200, 60, 45);
    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++; errors++;
    $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule